// File: doc/BRIEF.md
# Non-Blocking Miss Tracker

This block sits between a processor-side cache lookup and main memory and keeps the processor running while read misses are outstanding. Each request arrives with the cache's hit indication and hit data already resolved. A read that hits is answered on the next cycle. A read that misses claims a tracking entry that records its line address and the tags of the requesters waiting on it. The entry is queued toward memory and the requester is released at once. Memory replies carry the entry index, may come back in any order, and complete the entry by raising a wake mask with one bit for each waiting requester tag.

Writes do not wait for memory. They enter an in-order write buffer that drains to a separate memory write port. Every read first searches that buffer, and when buffered writes to the same address exist, the youngest of them supplies the data in place of the cache. A read miss to a line that is already being tracked joins the existing entry and does not issue a second memory read. A new miss stalls only when every entry is busy, and a write stalls only when the buffer is full.

Top module: `nb_miss_tracker`

## Requirements
- R1: While reset is held and just after it, hit_valid, fill_valid, mem_rd_valid and mem_wr_valid are low, and req_ready is high when no request is presented.
- R2: A read with req_hit high that matches no buffered write is accepted, and in the next cycle hit_valid is high with hit_tag equal to req_tag and hit_data equal to req_hit_data.
- R3: A read miss to a line with no live entry takes the lowest-numbered free entry while at least one is free, and req_ready stays high for it.
- R4: A read miss to an untracked line is stalled (req_ready low) while all N_ENT entries are busy; reads that hit, or that join a busy entry, are still accepted in that state.
- R5: A read miss to a line that already has a live entry is accepted, issues no further memory read, and adds its tag to that entry's wake mask.
- R6: A memory reply with mem_rsp_id = k produces, in the next cycle, fill_valid with fill_addr equal to entry k's line, fill_data equal to mem_rsp_data and fill_wake bit t set for each waiting tag t. Entry k is then free. Replies may arrive in any order.
- R7: A write is accepted into the write buffer while it holds fewer than WB_DEPTH writes, and is stalled (req_ready low) when it is full.
- R8: Buffered writes leave on mem_wr_* in arrival order, one per cycle in which mem_wr_valid and mem_wr_ready are both high. Address and data hold steady while the port is not ready.
- R9: A read whose address matches a buffered write is answered through hit_valid and hit_data in the next cycle with the data of the youngest matching write, whatever req_hit says, and it allocates no entry.
- R10: A read miss that joins entry k in the same cycle as the reply for entry k has its tag included in that reply's fill_wake.
- R11: Allocated entries are presented on mem_rd_* in allocation order, with mem_rd_id equal to the entry index. The presented request holds steady until mem_rd_ready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | DATA_W | Write data |
| req_tag | input | TAG_W | Requester tag |
| req_hit | input | 1 | Cache lookup hit for this read |
| req_hit_data | input | DATA_W | Cache data for a hit |
| hit_valid | output | 1 | Immediate read answer |
| hit_tag | output | TAG_W | Tag of the answered read |
| hit_data | output | DATA_W | Data of the answered read |
| mem_rd_valid | output | 1 | Memory read request present |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | ADDR_W | Line to read |
| mem_rd_id | output | $clog2(N_ENT) | Entry index of the request |
| mem_rsp_valid | input | 1 | Memory reply present |
| mem_rsp_id | input | $clog2(N_ENT) | Entry index of the reply |
| mem_rsp_data | input | DATA_W | Reply data |
| mem_wr_valid | output | 1 | Buffered write present |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | ADDR_W | Oldest buffered write address |
| mem_wr_data | output | DATA_W | Oldest buffered write data |
| fill_valid | output | 1 | Miss completed |
| fill_addr | output | ADDR_W | Completed line |
| fill_data | output | DATA_W | Completed data |
| fill_wake | output | 2**TAG_W | One bit per waiting requester tag |

## Verification
The hardest states to reach are a completely full entry file whose replies come back in an arbitrary order, and a joining miss that lands in the very cycle its entry's reply arrives. The stimulus holds mem_rd_ready low so that misses pile up until all entries are busy. It then presents a fresh miss, a hit and a joining miss in that saturated state, releases the read port, and replies in each of the 24 orders of four entries. For the same-cycle case, the joining read and the reply are driven on the same clock edge, and the wake mask that results is checked.

// File: rtl/nbmt_pkg.sv
package nbmt_pkg;

   // Outcome of the request presented in the current cycle
   typedef enum logic [2:0] {
      K_IDLE,
      K_RD_FWD,
      K_RD_HIT,
      K_RD_MERGE,
      K_RD_ALLOC,
      K_RD_STALL,
      K_WR_PUSH,
      K_WR_STALL
   } req_kind_e;

endpackage

// File: rtl/nbmt_pick.sv
// Lowest-index set bit finder.
module nbmt_pick #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);

   generate
      if (N == 1) begin : g_one
         assign found = vec[0];
         assign idx   = '0;
      end else begin : g_many
         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (vec[i]) begin
                  found = 1'b1;
                  idx   = IW'(i);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/nbmt_wbuf.sv
// In-order write buffer with youngest-match read forwarding.
module nbmt_wbuf #(
   parameter int AW    = 8,
   parameter int DW    = 16,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   output logic          full,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [AW-1:0] out_addr,
   output logic [DW-1:0] out_data,
   input  logic [AW-1:0] look_addr,
   output logic          look_hit,
   output logic [DW-1:0] look_data
);

   localparam int CW = $clog2(DEPTH + 1);

   logic [AW-1:0] a_q [DEPTH];
   logic [DW-1:0] d_q [DEPTH];
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] tgt;
   logic          pop;

   assign out_valid = (cnt_q != '0);
   assign full      = (cnt_q == CW'(DEPTH));
   assign out_addr  = a_q[0];
   assign out_data  = d_q[0];
   assign pop       = out_valid && out_ready;
   assign tgt       = cnt_q - CW'(pop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + CW'(push) - CW'(pop);
   end

   // slot 0 is the oldest; a pop shifts every slot down by one
   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (push && tgt == CW'(i)) begin
            a_q[i] <= push_addr;
            d_q[i] <= push_data;
         end else if (pop && i < DEPTH - 1) begin
            a_q[i] <= a_q[(i == DEPTH - 1) ? i : i + 1];
            d_q[i] <= d_q[(i == DEPTH - 1) ? i : i + 1];
         end
      end
   end

   // later slots are younger, so the last match wins
   always_comb begin
      look_hit  = 1'b0;
      look_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (CW'(i) < cnt_q && a_q[i] == look_addr) begin
            look_hit  = 1'b1;
            look_data = d_q[i];
         end
      end
   end

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   p_drain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_addr) && $stable(out_data)));

endmodule

// File: rtl/nbmt_mshr.sv
// Miss entry file: lookup, allocation, join, issue queue, reply completion.
module nbmt_mshr #(
   parameter int AW = 8,
   parameter int DW = 16,
   parameter int TW = 2,
   parameter int N  = 4,
   localparam int IW = $clog2(N),
   localparam int NT = 1 << TW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] look_addr,
   output logic          look_match,
   output logic [IW-1:0] look_idx,
   output logic          full,
   input  logic          alloc,
   input  logic [AW-1:0] alloc_addr,
   input  logic [TW-1:0] alloc_tag,
   input  logic          merge,
   input  logic [IW-1:0] merge_idx,
   input  logic [TW-1:0] merge_tag,
   output logic          mem_rd_valid,
   input  logic          mem_rd_ready,
   output logic [AW-1:0] mem_rd_addr,
   output logic [IW-1:0] mem_rd_id,
   input  logic          mem_rsp_valid,
   input  logic [IW-1:0] mem_rsp_id,
   input  logic [DW-1:0] mem_rsp_data,
   output logic          fill_valid,
   output logic [AW-1:0] fill_addr,
   output logic [DW-1:0] fill_data,
   output logic [NT-1:0] fill_wake
);

   logic [N-1:0]  v_q, iss_q;
   logic [AW-1:0] addr_q [N];
   logic [NT-1:0] wait_q [N];
   logic [IW-1:0] q_idx  [N];
   logic [IW-1:0] rp_q, wp_q;
   logic [IW:0]   qc_q;
   logic [N-1:0]  match_vec;
   logic          free_found;
   logic [IW-1:0] free_idx;
   logic          ipop;
   logic [NT-1:0] merge_bit, alloc_bit;

   function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
      return (p == IW'(N - 1)) ? '0 : p + IW'(1);
   endfunction

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_match
         assign match_vec[g] = v_q[g] && (addr_q[g] == look_addr);
      end
   endgenerate

   nbmt_pick #(.N(N)) u_match (.vec(match_vec), .found(look_match), .idx(look_idx));
   nbmt_pick #(.N(N)) u_free  (.vec(~v_q),      .found(free_found), .idx(free_idx));

   assign full         = !free_found;
   assign mem_rd_valid = (qc_q != '0);
   assign mem_rd_id    = q_idx[rp_q];
   assign mem_rd_addr  = addr_q[q_idx[rp_q]];
   assign ipop         = mem_rd_valid && mem_rd_ready;
   assign merge_bit    = NT'(1) << merge_tag;
   assign alloc_bit    = NT'(1) << alloc_tag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q        <= '0;
         iss_q      <= '0;
         rp_q       <= '0;
         wp_q       <= '0;
         qc_q       <= '0;
         fill_valid <= 1'b0;
      end else begin
         for (int i = 0; i < N; i++) begin
            if (mem_rsp_valid && mem_rsp_id == IW'(i)) begin
               v_q[i]   <= 1'b0;
               iss_q[i] <= 1'b0;
            end else if (alloc && free_idx == IW'(i)) begin
               v_q[i]   <= 1'b1;
               iss_q[i] <= 1'b0;
            end else if (ipop && mem_rd_id == IW'(i)) begin
               iss_q[i] <= 1'b1;
            end
         end
         if (alloc) wp_q <= nxt(wp_q);
         if (ipop)  rp_q <= nxt(rp_q);
         qc_q       <= qc_q + (IW+1)'(alloc) - (IW+1)'(ipop);
         fill_valid <= mem_rsp_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (alloc) begin
         addr_q[free_idx] <= alloc_addr;
         q_idx[wp_q]      <= free_idx;
      end
      for (int i = 0; i < N; i++) begin
         if (alloc && free_idx == IW'(i))
            wait_q[i] <= alloc_bit;
         else if (merge && merge_idx == IW'(i) &&
                  !(mem_rsp_valid && mem_rsp_id == IW'(i)))
            wait_q[i] <= wait_q[i] | merge_bit;
      end
      if (mem_rsp_valid) begin
         fill_addr <= addr_q[mem_rsp_id];
         fill_data <= mem_rsp_data;
         fill_wake <= wait_q[mem_rsp_id] |
                      ((merge && merge_idx == mem_rsp_id) ? merge_bit : '0);
      end
   end

   p_reply_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> (v_q[mem_rsp_id] && iss_q[mem_rsp_id]));

   p_fill_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> (fill_wake != '0));

   p_no_dup_r5: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> !look_match);

   p_issue_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=>
         (mem_rd_valid && $stable(mem_rd_id) && $stable(mem_rd_addr)));

   p_queue_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      qc_q <= (IW+1)'(N));

endmodule

// File: rtl/nb_miss_tracker.sv
module nb_miss_tracker
   import nbmt_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 16,
   parameter int TAG_W    = 2,
   parameter int N_ENT    = 4,
   parameter int WB_DEPTH = 4,
   localparam int IW = $clog2(N_ENT),
   localparam int NT = 1 << TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic              req_hit,
   input  logic [DATA_W-1:0] req_hit_data,
   output logic              hit_valid,
   output logic [TAG_W-1:0]  hit_tag,
   output logic [DATA_W-1:0] hit_data,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [ADDR_W-1:0] mem_rd_addr,
   output logic [IW-1:0]     mem_rd_id,
   input  logic              mem_rsp_valid,
   input  logic [IW-1:0]     mem_rsp_id,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic              fill_valid,
   output logic [ADDR_W-1:0] fill_addr,
   output logic [DATA_W-1:0] fill_data,
   output logic [NT-1:0]     fill_wake
);

   generate
      if (N_ENT < 2 || N_ENT > 16) begin : g_bad_ent
         $error("N_ENT must lie in 2..16");
      end
      if (WB_DEPTH < 1 || WB_DEPTH > 32) begin : g_bad_wb
         $error("WB_DEPTH must lie in 1..32");
      end
      if (TAG_W < 1 || TAG_W > 5) begin : g_bad_tag
         $error("TAG_W must lie in 1..5");
      end
   endgenerate

   req_kind_e         kind;
   logic              wb_full, wb_hit;
   logic [DATA_W-1:0] wb_data;
   logic              ms_match, ms_full;
   logic [IW-1:0]     ms_idx;

   nbmt_wbuf #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (kind == K_WR_PUSH),
      .push_addr (req_addr),
      .push_data (req_wdata),
      .full      (wb_full),
      .out_valid (mem_wr_valid),
      .out_ready (mem_wr_ready),
      .out_addr  (mem_wr_addr),
      .out_data  (mem_wr_data),
      .look_addr (req_addr),
      .look_hit  (wb_hit),
      .look_data (wb_data)
   );

   nbmt_mshr #(.AW(ADDR_W), .DW(DATA_W), .TW(TAG_W), .N(N_ENT)) u_mshr (
      .clk           (clk),
      .rst_n         (rst_n),
      .look_addr     (req_addr),
      .look_match    (ms_match),
      .look_idx      (ms_idx),
      .full          (ms_full),
      .alloc         (kind == K_RD_ALLOC),
      .alloc_addr    (req_addr),
      .alloc_tag     (req_tag),
      .merge         (kind == K_RD_MERGE),
      .merge_idx     (ms_idx),
      .merge_tag     (req_tag),
      .mem_rd_valid  (mem_rd_valid),
      .mem_rd_ready  (mem_rd_ready),
      .mem_rd_addr   (mem_rd_addr),
      .mem_rd_id     (mem_rd_id),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_id    (mem_rsp_id),
      .mem_rsp_data  (mem_rsp_data),
      .fill_valid    (fill_valid),
      .fill_addr     (fill_addr),
      .fill_data     (fill_data),
      .fill_wake     (fill_wake)
   );

   // buffered writes outrank the cache; joins outrank allocation
   always_comb begin
      kind = K_IDLE;
      if (req_valid) begin
         if (req_write)     kind = wb_full ? K_WR_STALL : K_WR_PUSH;
         else if (wb_hit)   kind = K_RD_FWD;
         else if (req_hit)  kind = K_RD_HIT;
         else if (ms_match) kind = K_RD_MERGE;
         else if (ms_full)  kind = K_RD_STALL;
         else               kind = K_RD_ALLOC;
      end
   end

   assign req_ready = (kind != K_RD_STALL) && (kind != K_WR_STALL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_valid <= 1'b0;
      else        hit_valid <= (kind == K_RD_FWD) || (kind == K_RD_HIT);
   end

   always_ff @(posedge clk) begin
      hit_tag  <= req_tag;
      hit_data <= (kind == K_RD_FWD) ? wb_data : req_hit_data;
   end

   p_hit_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_hit && req_ready) |=> hit_valid);

   p_write_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !req_ready) |-> mem_wr_valid);

endmodule

// File: tb/sim_nb_miss_tracker.sv
`timescale 1ns/1ps
module sim_nb_miss_tracker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 0, req_write = 0, req_hit = 0;
   logic [7:0]  req_addr = 0;
   logic [15:0] req_wdata = 0, req_hit_data = 0;
   logic [1:0]  req_tag = 0;
   logic        req_ready;
   logic        hit_valid;
   logic [1:0]  hit_tag;
   logic [15:0] hit_data;
   logic        mem_rd_valid, mem_rd_ready = 0;
   logic [7:0]  mem_rd_addr;
   logic [1:0]  mem_rd_id;
   logic        mem_rsp_valid = 0;
   logic [1:0]  mem_rsp_id = 0;
   logic [15:0] mem_rsp_data = 0;
   logic        mem_wr_valid, mem_wr_ready = 0;
   logic [7:0]  mem_wr_addr;
   logic [15:0] mem_wr_data;
   logic        fill_valid;
   logic [7:0]  fill_addr;
   logic [15:0] fill_data;
   logic [3:0]  fill_wake;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   nb_miss_tracker u0 (.*);

   task automatic chk(input string rq, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // drive one request for one cycle; caller sits at a falling edge
   task automatic rq(input logic wr, input logic [7:0] a, input logic [15:0] d,
                     input logic [1:0] t, input logic h, input logic [15:0] hd,
                     output logic rdy);
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
      req_tag = t; req_hit = h; req_hit_data = hd;
      #1 rdy = req_ready;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic run_perm(input int p, input int o0, input int o1, input int o2, input int o3);
      int ord[4];
      logic rdy;
      ord[0] = o0; ord[1] = o1; ord[2] = o2; ord[3] = o3;
      mem_rd_ready = 0;
      for (int k = 0; k < 4; k++) begin
         rq(0, 8'(p*8 + k), 0, 2'(k), 0, 0, rdy);
         chk("R3", "miss accepted", rdy, 1);
         chk("R11", "head id held", mem_rd_id, 0);
         chk("R11", "head addr held", mem_rd_addr, p*8);
      end
      rq(0, 8'(p*8 + 4), 0, 0, 0, 0, rdy);
      chk("R4", "new miss stalls when full", rdy, 0);
      rq(0, 8'(p*8 + 5), 0, 1, 1, 16'(p*3 + 7), rdy);
      chk("R4", "hit accepted when full", rdy, 1);
      chk("R2", "hit valid", hit_valid, 1);
      chk("R2", "hit tag", hit_tag, 1);
      chk("R2", "hit data", hit_data, p*3 + 7);
      rq(0, 8'(p*8 + 1), 0, 2, 0, 0, rdy);
      chk("R5", "join accepted when full", rdy, 1);
      chk("R5", "join gives no hit", hit_valid, 0);
      mem_rd_ready = 1;
      for (int k = 0; k < 4; k++) begin
         chk("R11", "rd valid", mem_rd_valid, 1);
         chk("R11", "rd id order", mem_rd_id, k);
         chk("R11", "rd addr", mem_rd_addr, p*8 + k);
         @(negedge clk);
      end
      mem_rd_ready = 0;
      chk("R5", "no extra memory read", mem_rd_valid, 0);
      for (int j = 0; j < 4; j++) begin
         mem_rsp_valid = 1; mem_rsp_id = 2'(ord[j]);
         mem_rsp_data = 16'(16'hA000 + p*16 + ord[j]);
         @(negedge clk);
         mem_rsp_valid = 0;
         chk("R6", "fill valid", fill_valid, 1);
         chk("R6", "fill addr", fill_addr, p*8 + ord[j]);
         chk("R6", "fill data", fill_data, 16'hA000 + p*16 + ord[j]);
         chk("R6", "fill wake", fill_wake, (ord[j] == 1) ? 6 : (1 << ord[j]));
      end
      @(negedge clk);
      chk("R6", "fill single cycle", fill_valid, 0);
   endtask

   initial begin
      logic rdy;
      int pn;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "ready in reset", req_ready, 1);
      chk("R1", "hit_valid in reset", hit_valid, 0);
      chk("R1", "fill_valid in reset", fill_valid, 0);
      chk("R1", "mem_rd_valid in reset", mem_rd_valid, 0);
      chk("R1", "mem_wr_valid in reset", mem_wr_valid, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1", "hit_valid after reset", hit_valid, 0);
      chk("R1", "mem_rd_valid after reset", mem_rd_valid, 0);

      // every reply order of a full entry file
      pn = 0;
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++)
               for (int d = 0; d < 4; d++)
                  if (a != b && a != c && a != d && b != c && b != d && c != d) begin
                     run_perm(pn, a, b, c, d);
                     pn++;
                  end

      // write buffer: fill, stall, forward, drain
      mem_wr_ready = 0;
      rq(1, 8'h10, 16'h1111, 0, 0, 0, rdy); chk("R7", "write 0 accepted", rdy, 1);
      chk("R8", "drain head addr", mem_wr_addr, 8'h10);
      rq(1, 8'h20, 16'h2222, 0, 0, 0, rdy); chk("R7", "write 1 accepted", rdy, 1);
      rq(1, 8'h10, 16'h3333, 0, 0, 0, rdy); chk("R7", "write 2 accepted", rdy, 1);
      rq(1, 8'h30, 16'h4444, 0, 0, 0, rdy); chk("R7", "write 3 accepted", rdy, 1);
      rq(1, 8'h50, 16'h5555, 0, 0, 0, rdy); chk("R7", "write stalls when full", rdy, 0);
      chk("R8", "head held while not ready", mem_wr_data, 16'h1111);
      rq(0, 8'h10, 0, 2, 1, 16'hBEEF, rdy);
      chk("R9", "fwd valid", hit_valid, 1);
      chk("R9", "youngest write wins", hit_data, 16'h3333);
      chk("R9", "fwd tag", hit_tag, 2);
      rq(0, 8'h20, 0, 3, 0, 0, rdy);
      chk("R9", "fwd on cache miss", hit_data, 16'h2222);
      chk("R9", "fwd allocates nothing", mem_rd_valid, 0);
      rq(0, 8'h60, 0, 1, 1, 16'h6060, rdy);
      chk("R2", "unmatched read takes cache data", hit_data, 16'h6060);
      mem_wr_ready = 1;
      for (int k = 0; k < 4; k++) begin
         chk("R8", "drain valid", mem_wr_valid, 1);
         chk("R8", "drain addr order", mem_wr_addr, (k == 0 || k == 2) ? 8'h10 : (k == 1 ? 8'h20 : 8'h30));
         chk("R8", "drain data order", mem_wr_data, 16'h1111 * (k + 1));
         @(negedge clk);
      end
      chk("R8", "buffer empty", mem_wr_valid, 0);
      mem_wr_ready = 0;
      rq(0, 8'h10, 0, 0, 1, 16'h7777, rdy);
      chk("R9", "no stale forward after drain", hit_data, 16'h7777);

      // join landing on the reply cycle
      mem_rd_ready = 1;
      rq(0, 8'h90, 0, 0, 0, 0, rdy);
      chk("R3", "lowest free entry", mem_rd_id, 0);
      @(negedge clk);
      mem_rd_ready = 0;
      mem_rsp_valid = 1; mem_rsp_id = 0; mem_rsp_data = 16'h5A5A;
      rq(0, 8'h90, 0, 1, 0, 0, rdy);
      mem_rsp_valid = 0;
      chk("R10", "join accepted", rdy, 1);
      chk("R10", "fill valid", fill_valid, 1);
      chk("R10", "wake includes joiner", fill_wake, 4'b0011);
      chk("R10", "fill data", fill_data, 16'h5A5A);
      chk("R10", "no new read", mem_rd_valid, 0);
      @(negedge clk);
      chk("R10", "fill single cycle", fill_valid, 0);

      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule